// File: doc/BRIEF.md
# Line-to-Message Interrupt Redirector

This block turns a bank of wired interrupt inputs into memory-write interrupt messages. Every input line owns a two-word redirection entry that decides whether the line may fire and how it fires. The control word holds a mask bit, the trigger kind (edge or level), the polarity and a one-byte message value. The destination word holds a 16-bit target field that becomes the upper half of the write address. Software never sees the entries directly. It writes an internal index into a select register and then reads or writes that entry through a data window.

A level-triggered line sends one message and then enters an in-service state, in which it ignores its input. It leaves that state when software writes a matching value to the end-of-interrupt register. If the input is still active at that point, a fresh message follows. An edge-triggered line sends one message for each inactive-to-active transition. Pending lines compete for a single valid/ready message port, and the lowest-numbered line wins. The port register holds a loaded message until the sink accepts it. While the port is stalled, every other pending request stays latched in its line.

Top module: `irq_redirector`

## Requirements
- R1: After reset every entry reads back masked with all other fields zero (control word 0x00010000, destination word 0), the select register reads 0 and msg_valid is low.
- R2: Bus offset 0x00 is the select register (bits 7:0, read back as written). Offset 0x10 is the data window onto the selected internal register. A write to the window is ignored for read-only or unimplemented indices. Reads of unimplemented indices, and of any bus offset other than 0x00 and 0x10, return zero.
- R3: Internal index 0x01 is read-only. It returns the version parameter in bits 7:0 and NUM_LINES-1 in bits 23:16, and writes to it have no effect.
- R4: Line n's control word sits at index 0x10+2n and its destination word at 0x11+2n. A write to one entry leaves every other entry unchanged.
- R5: The control word stores only these fields: bit 16 (mask), bit 15 (level), bit 13 (active-low), bit 8 (lowest-priority flag) and bits 7:0 (message value). All other bits read zero. The destination word stores only bits 31:16. A message from line n carries msg_addr = {dest, 16'h0} and msg_data = {23'b0, flag, value}.
- R6: Inputs pass through a two-flop synchronizer, and the active-low bit inverts the input before detection. With the port idle, msg_valid rises at the fourth rising clock edge after an input changes to its active level.
- R7: An edge-triggered line (bit 15 = 0) sends exactly one message per inactive-to-active transition. Holding the input active sends nothing more.
- R8: A level-triggered line sends one message and then stays in service, ignoring its input, until a matching end-of-interrupt.
- R9: A write to bus offset 0x40 compares its bits 7:0 with the message value of each level-triggered line. Matching lines leave service and fire again if still active. Non-matching lines and inactive lines send nothing.
- R10: While its mask bit is set, a line sends nothing, and an edge seen while masked is discarded. Unmasking a level line whose input is active sends a message.
- R11: When several lines are pending, the lowest-numbered line is sent first.
- R12: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data hold steady. A message transfers on a clock edge with both high, and no pending request is lost during the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Raw interrupt input lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Sink accepts the message |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
Several internal faults show up at the ports within one to a few cycles. A lost pending bit appears as a missing message about four cycles after an input change. A stuck in-service bit appears as no message after an end-of-interrupt, and a wrong arbitration choice appears as the wrong message value on the first message after a stall. The reference model mirrors the per-line state in the bench, and its output is compared on every clock. A divergence in message timing or content is therefore flagged in the cycle it appears, not only at the end of a scenario.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam logic [7:0] OFF_SELECT = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;
  localparam logic [7:0] OFF_EOI    = 8'h40;

  localparam logic [7:0] IDX_VERSION = 8'h01;
  localparam int         IDX_BASE    = 16;

  localparam int BIT_MASK   = 16;
  localparam int BIT_LEVEL  = 15;
  localparam int BIT_ACTLOW = 13;
  localparam int BIT_LOWPRI = 8;

  typedef struct packed {
    logic        masked;
    logic        level;
    logic        act_low;
    logic        lowpri;
    logic [7:0]  vec;
    logic [15:0] dest;
  } redir_entry_t;

  localparam redir_entry_t ENTRY_RESET = '{masked: 1'b1, level: 1'b0, act_low: 1'b0,
                                           lowpri: 1'b0, vec: 8'h00, dest: 16'h0000};

  function automatic logic [31:0] pack_ctrl(redir_entry_t e);
    logic [31:0] w;
    w = '0;
    w[BIT_MASK]   = e.masked;
    w[BIT_LEVEL]  = e.level;
    w[BIT_ACTLOW] = e.act_low;
    w[BIT_LOWPRI] = e.lowpri;
    w[7:0]        = e.vec;
    return w;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic       masked,
  input  logic       level,
  input  logic       act_low,
  input  logic [7:0] vec,
  input  logic       grant,
  input  logic       eoi_wr,
  input  logic [7:0] eoi_vec,
  output logic       req
);
  logic act, act_q, pending, in_svc;
  logic fire_edge, fire_lvl, eoi_hit;

  assign act       = sync_in ^ act_low;
  assign fire_edge = !level && act && !act_q;
  assign fire_lvl  = level && act && !in_svc && !pending;
  assign eoi_hit   = eoi_wr && level && (vec == eoi_vec);
  assign req       = pending && !masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      pending <= 1'b0;
      in_svc  <= 1'b0;
    end else begin
      act_q <= act;
      if (grant) pending <= 1'b0;
      if (!masked && (fire_edge || fire_lvl)) pending <= 1'b1;
      if (grant && level) in_svc <= 1'b1;
      else if (eoi_hit)   in_svc <= 1'b0;
    end
  end

  assert_svc_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_svc) |-> !pending);

  assert_masked_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (masked && !level) |=> !$rose(pending));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             take,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] sel_idx,
  output logic             any
);
  logic found;

  always_comb begin
    found   = 1'b0;
    sel_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        found   = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end

  assign any = found;

  always_comb begin
    grant = '0;
    if (take && found) grant[sel_idx] = 1'b1;
  end

  assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_lowest_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((req & (grant - 1'b1)) == '0));
endmodule

// File: rtl/irq_redirector.sv
module irq_redirector
  import irq_redir_pkg::*;
#(
  parameter int         NUM_LINES = 8,
  parameter logic [7:0] VERSION   = 8'h21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [31:0]          msg_addr,
  output logic [31:0]          msg_data
);
  localparam int          IDX_W        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [31:0] VERSION_WORD = {8'h00, 8'(NUM_LINES - 1), 8'h00, VERSION};

  logic [7:0]           sel_q;
  redir_entry_t         cfg [NUM_LINES];
  logic [NUM_LINES-1:0] sync_q, req, grant;
  logic [IDX_W-1:0]     win_idx;
  logic                 any_req, out_free, win_wr, eoi_wr;
  logic [31:0]          win_rdata;
  logic                 unused_wbits;

  assign unused_wbits = ^{bus_wdata[14], bus_wdata[12:9]};
  assign win_wr = bus_wr && (bus_addr == OFF_WINDOW);
  assign eoi_wr = bus_wr && (bus_addr == OFF_EOI);

  // Register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int n = 0; n < NUM_LINES; n++) cfg[n] <= ENTRY_RESET;
    end else begin
      if (bus_wr && bus_addr == OFF_SELECT) sel_q <= bus_wdata[7:0];
      for (int n = 0; n < NUM_LINES; n++) begin
        if (win_wr && sel_q == 8'(IDX_BASE + 2*n)) begin
          cfg[n].masked  <= bus_wdata[BIT_MASK];
          cfg[n].level   <= bus_wdata[BIT_LEVEL];
          cfg[n].act_low <= bus_wdata[BIT_ACTLOW];
          cfg[n].lowpri  <= bus_wdata[BIT_LOWPRI];
          cfg[n].vec     <= bus_wdata[7:0];
        end
        if (win_wr && sel_q == 8'(IDX_BASE + 2*n + 1))
          cfg[n].dest <= bus_wdata[31:16];
      end
    end
  end

  always_comb begin
    win_rdata = '0;
    if (sel_q == IDX_VERSION) win_rdata = VERSION_WORD;
    for (int n = 0; n < NUM_LINES; n++) begin
      if (sel_q == 8'(IDX_BASE + 2*n))     win_rdata = pack_ctrl(cfg[n]);
      if (sel_q == 8'(IDX_BASE + 2*n + 1)) win_rdata = {cfg[n].dest, 16'h0000};
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_SELECT: bus_rdata = {24'h0, sel_q};
      OFF_WINDOW: bus_rdata = win_rdata;
      default:    bus_rdata = '0;
    endcase
  end

  // Input conditioning and per-line state
  irq_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(sync_q)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_line_ctrl u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_in (sync_q[g]),
      .masked  (cfg[g].masked),
      .level   (cfg[g].level),
      .act_low (cfg[g].act_low),
      .vec     (cfg[g].vec),
      .grant   (grant[g]),
      .eoi_wr  (eoi_wr),
      .eoi_vec (bus_wdata[7:0]),
      .req     (req[g])
    );
  end

  // Arbitration and message output register
  assign out_free = !msg_valid || msg_ready;

  irq_prio_arb #(.N(NUM_LINES), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .take(out_free),
    .grant(grant), .sel_idx(win_idx), .any(any_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (out_free) begin
      msg_valid <= any_req;
      if (any_req) begin
        msg_addr <= {cfg[win_idx].dest, 16'h0000};
        msg_data <= {23'h0, cfg[win_idx].lowpri, cfg[win_idx].vec};
      end
    end
  end

  assert_msg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
endmodule

// File: tb/irq_redirector_tb.sv
module irq_redirector_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         msg_valid, msg_ready = 1'b1;
  logic [31:0]  msg_addr, msg_data;

  int errors = 0, checks = 0;
  bit chk_on = 0;
  int got_q[$];

  always #10 clk = ~clk;

  irq_redirector #(.NUM_LINES(N), .VERSION(8'h21)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit m_mask[N], m_lvl[N], m_alo[N], m_lp[N];
  int m_vec[N], m_dest[N];
  bit s1[N], s2[N], aq[N], pend[N], isvc[N];
  bit mv;
  int maddr, mdata, msel;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_mask[i] = 1; m_lvl[i] = 0; m_alo[i] = 0; m_lp[i] = 0; m_vec[i] = 0; m_dest[i] = 0;
        s1[i] = 0; s2[i] = 0; aq[i] = 0; pend[i] = 0; isvc[i] = 0;
      end
      mv = 0; maddr = 0; mdata = 0; msel = 0;
    end else begin
      bit free;
      int win;
      free = !mv || msg_ready;
      win = -1;
      for (int i = N - 1; i >= 0; i--) if (pend[i] && !m_mask[i]) win = i;
      if (free) begin
        mv = (win >= 0);
        if (win >= 0) begin
          maddr = m_dest[win] << 16;
          mdata = (int'(m_lp[win]) << 8) | m_vec[win];
        end
      end
      for (int i = 0; i < N; i++) begin
        bit act, fe, fl, g, eoi;
        act = s2[i] ^ m_alo[i];
        fe  = !m_lvl[i] && act && !aq[i];
        fl  = m_lvl[i] && act && !isvc[i] && !pend[i];
        g   = free && (i == win);
        eoi = bus_wr && bus_addr == 8'h40 && m_lvl[i] && m_vec[i] == int'(bus_wdata[7:0]);
        if (g) pend[i] = 0;
        if (!m_mask[i] && (fe || fl)) pend[i] = 1;
        if (g && m_lvl[i]) isvc[i] = 1;
        else if (eoi) isvc[i] = 0;
        aq[i] = act; s2[i] = s1[i]; s1[i] = irq_in[i];
      end
      if (bus_wr && bus_addr == 8'h00) msel = int'(bus_wdata[7:0]);
      if (bus_wr && bus_addr == 8'h10 && msel >= 16 && msel < 16 + 2*N) begin
        int n;
        n = (msel - 16) / 2;
        if (msel % 2 == 0) begin
          m_mask[n] = bus_wdata[16]; m_lvl[n] = bus_wdata[15]; m_alo[n] = bus_wdata[13];
          m_lp[n] = bus_wdata[8]; m_vec[n] = int'(bus_wdata[7:0]);
        end else m_dest[n] = int'(bus_wdata[31:16]);
      end
    end
  end

  // Per-cycle comparison and message log
  always @(negedge clk) begin
    if (chk_on) begin
      chk(msg_valid == mv, "R12 model msg_valid", int'(msg_valid), int'(mv));
      if (mv) begin
        chk(msg_addr == maddr, "R5 model msg_addr", msg_addr, maddr);
        chk(msg_data == mdata, "R5 model msg_data", msg_data, mdata);
      end
      if (msg_valid && msg_ready) got_q.push_back(int'(msg_data));
    end
  end

  task automatic bwr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_addr = 8'h00; bus_wdata = '0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a;
    #2;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
    bus_addr = 8'h00;
  endtask

  task automatic idx_chk(int idx, logic [31:0] exp, string tag);
    bwr(8'h00, 32'(idx));
    rd_chk(8'h10, exp, tag);
  endtask

  task automatic set_entry(int n, logic [31:0] lo, logic [31:0] hi);
    bwr(8'h00, 32'(16 + 2*n)); bwr(8'h10, lo);
    bwr(8'h00, 32'(17 + 2*n)); bwr(8'h10, hi);
  endtask

  task automatic waitc(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    waitc(3);
    rst_n = 1;
    chk_on = 1;
    // R1 reset state
    chk(msg_valid == 0, "R1 msg_valid after reset", int'(msg_valid), 0);
    rd_chk(8'h00, 32'h0, "R1 select reset");
    idx_chk(16, 32'h0001_0000, "R1 line0 ctrl reset");
    idx_chk(17, 32'h0, "R1 line0 dest reset");
    idx_chk(16 + 2*7, 32'h0001_0000, "R1 line7 ctrl reset");
    // R3 version
    idx_chk(1, 32'h0007_0021, "R3 version read");
    bwr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h0007_0021, "R3 version write ignored");
    // R2 / R5 field storage
    bwr(8'h00, 32'h12);
    rd_chk(8'h00, 32'h12, "R2 select readback");
    bwr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h0001_A1FF, "R5 ctrl writable bits");
    idx_chk(19, 32'h0, "R4 line1 dest untouched");
    bwr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'hFFFF_0000, "R5 dest writable bits");
    idx_chk(18, 32'h0001_A1FF, "R4 line1 ctrl kept");
    idx_chk(5, 32'h0, "R2 unimplemented index");
    bwr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h0, "R2 write to unimplemented index ignored");
    idx_chk(16 + 2*N, 32'h0, "R2 index past last line");
    rd_chk(8'h20, 32'h0, "R2 unmapped bus offset");
    // R4 addressing: line 5 vs line 4
    set_entry(5, 32'h0000_8155, 32'h5555_0000);
    idx_chk(16 + 2*5, 32'h0000_8155, "R4 line5 ctrl");
    idx_chk(17 + 2*5, 32'h5555_0000, "R4 line5 dest");
    idx_chk(16 + 2*4, 32'h0001_0000, "R4 line4 untouched");
    set_entry(1, 32'h0001_0000, 32'h0);
    set_entry(5, 32'h0001_0000, 32'h0);

    // R6/R5/R7 edge line 3
    set_entry(3, 32'h0000_0033, 32'h1234_0000);
    waitc(2);
    got_q.delete();
    @(negedge clk) irq_in[3] = 1;
    waitc(3);
    chk(msg_valid == 0, "R6 not before 4th edge", int'(msg_valid), 0);
    waitc(1);
    chk(msg_valid == 1, "R6 valid at 4th edge", int'(msg_valid), 1);
    chk(msg_addr == 32'h1234_0000, "R5 message address", msg_addr, 32'h1234_0000);
    waitc(20);
    chk(got_q.size() == 1, "R7 one message while held", got_q.size(), 1);
    @(negedge clk) irq_in[3] = 0;
    waitc(6);
    @(negedge clk) irq_in[3] = 1;
    waitc(8);
    chk(got_q.size() == 2, "R7 second edge second message", got_q.size(), 2);
    irq_in[3] = 0;

    // R6 polarity, R5 lowpri flag: line 4 active-low edge
    irq_in[4] = 1;
    waitc(4);
    set_entry(4, 32'h0000_2144, 32'h0044_0000);
    waitc(4);
    got_q.delete();
    @(negedge clk) irq_in[4] = 0;
    waitc(8);
    chk(got_q.size() == 1, "R6 active-low fires on falling input", got_q.size(), 1);
    if (got_q.size() > 0) chk(got_q[0] == 32'h144, "R5 data with flag", got_q[0], 32'h144);

    // R8/R9 level line 1
    set_entry(1, 32'h0000_8011, 32'hAB00_0000);
    waitc(2);
    got_q.delete();
    @(negedge clk) irq_in[1] = 1;
    waitc(25);
    chk(got_q.size() == 1, "R8 single message while in service", got_q.size(), 1);
    bwr(8'h40, 32'h22);
    waitc(8);
    chk(got_q.size() == 1, "R9 non-matching EOI ignored", got_q.size(), 1);
    bwr(8'h40, 32'h11);
    waitc(8);
    chk(got_q.size() == 2, "R9 matching EOI refires", got_q.size(), 2);
    @(negedge clk) irq_in[1] = 0;
    waitc(4);
    bwr(8'h40, 32'h11);
    waitc(8);
    chk(got_q.size() == 2, "R9 EOI with inactive input", got_q.size(), 2);

    // R10 masking
    set_entry(6, 32'h0001_0066, 32'h0);
    got_q.delete();
    @(negedge clk) irq_in[6] = 1;
    waitc(8);
    @(negedge clk) irq_in[6] = 0;
    waitc(4);
    set_entry(6, 32'h0000_0066, 32'h0);
    waitc(8);
    chk(got_q.size() == 0, "R10 masked edge discarded", got_q.size(), 0);
    set_entry(7, 32'h0001_8077, 32'h0077_0000);
    @(negedge clk) irq_in[7] = 1;
    waitc(10);
    chk(got_q.size() == 0, "R10 masked level silent", got_q.size(), 0);
    set_entry(7, 32'h0000_8077, 32'h0077_0000);
    waitc(6);
    chk(got_q.size() == 1, "R10 unmask active level fires", got_q.size(), 1);
    if (got_q.size() > 0) chk(got_q[0] == 32'h77, "R10 unmask message value", got_q[0], 32'h77);

    // R11/R12 priority under stall
    set_entry(2, 32'h0000_0022, 32'h0002_0000);
    set_entry(5, 32'h0000_0055, 32'h0005_0000);
    waitc(2);
    got_q.delete();
    @(negedge clk) begin msg_ready = 0; irq_in[2] = 1; irq_in[5] = 1; end
    waitc(6);
    chk(msg_valid == 1, "R12 valid during stall", int'(msg_valid), 1);
    chk(msg_data == 32'h22, "R11 lowest line first", msg_data, 32'h22);
    waitc(10);
    chk(msg_data == 32'h22 && msg_addr == 32'h0002_0000, "R12 held during stall", msg_data, 32'h22);
    @(negedge clk) msg_ready = 1;
    waitc(6);
    chk(got_q.size() == 2, "R12 nothing lost after stall", got_q.size(), 2);
    if (got_q.size() == 2) chk(got_q[1] == 32'h55, "R11 second line after first", got_q[1], 32'h55);

    waitc(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule